// File: doc/BRIEF.md
# External Interrupt Sense and Flag Unit

This block watches eight asynchronous external interrupt request lines. Each line goes through a two-stage synchroniser and then to its own detector. Software picks the detector's sensing mode: low level, falling edge, rising edge, or either edge. When a detector sees its condition, it sets a sticky status flag for that line.

Software reaches four byte-wide registers over a small register bus: two mode registers, one status register and one enable register. A status flag is cleared by writing 0 to its bit. The single interrupt output is raised whenever any flag is set and its enable bit is also set.

A hardware-standby input clears the register state in the same way as reset. The block does not arbitrate between lines, supply vectors or include a processor.

Top module: `xirq_unit`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_o` is 0.
- R2: Address 0 holds the mode fields for inputs 7..4 and address 1 holds those for inputs 3..0. Input n uses bits [2*(n%4)+1 : 2*(n%4)] of its register. Address 2 is the status flags, with bit n for input n. Address 3 is the enable mask. All four registers read back what was written, except the status flags (see R7).
- R3: Mode code 2'b00 is low-level sensing. The flag is set on every clock in which the synchronised input is low. Once the input is high again, a clear sticks.
- R4: Mode code 2'b01 sets the flag on a high-to-low transition of the input only.
- R5: Mode code 2'b10 sets the flag on a low-to-high transition of the input only.
- R6: Mode code 2'b11 sets the flag on a transition in either direction.
- R7: A write to address 2 clears each flag whose data bit is 0. A data bit of 1 leaves that flag unchanged. The bus never sets a flag.
- R8: If a detected event and a clear of the same flag occur in the same clock, the flag stays set.
- R9: `irq_o` equals the OR over all inputs of (flag AND enable bit). Clearing an enable bit masks the flag from `irq_o` without changing the flag.
- R10: While `standby_i` is high, both mode registers, the flags and the enable mask are forced to 0x00.
- R11: Changing an input's mode field while that input is static never sets its flag. The edge history is reloaded in the clock of the change.
- R12: A change on an input reaches its flag, and `irq_o`, on the third rising clock edge after the change: two edges for the synchroniser and one for the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| standby_i | input | 1 | Hardware standby; clears mode, flag and enable registers |
| req_i | input | 8 | Asynchronous external interrupt request lines |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, a combinational function of the address |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
A change on a request line shows up in the flags and on `irq_o` after exactly three rising edges. The bench checks this directly: the flag must still be clear one sample after the second edge and set one sample after the third. In all other tests the bench waits four edges before reading, so synchroniser latency cannot affect the result.

Register writes take effect at the first rising edge after they are driven. Reads are combinational and are sampled 1 ns after the address settles, away from any clock edge. Standby and clears are checked from the first sample after the edge that applied them.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_MODE_HI = 2'd0;
  localparam logic [1:0] ADDR_MODE_LO = 2'd1;
  localparam logic [1:0] ADDR_FLAGS   = 2'd2;
  localparam logic [1:0] ADDR_ENABLE  = 2'd3;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  // Idle level of a request line is high, so the stages reset to ones.
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   lvl_i,
  input  sense_e mode_i,
  input  logic   reload_i,
  output logic   evt_o
);

  logic hist_q;
  logic hist_d;
  logic cond;

  // History always follows the synchronised level; a mode change reloads it
  // with that same level while the comparison of this clock is discarded.
  assign hist_d = lvl_i;

  always_comb begin
    case (mode_i)
      SENSE_LOW:  cond = !lvl_i;
      SENSE_FALL: cond = hist_q && !lvl_i;
      SENSE_RISE: cond = !hist_q && lvl_i;
      SENSE_BOTH: cond = hist_q ^ lvl_i;
      default:    cond = 1'b0;
    endcase
  end

  assign evt_o = cond && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b1;
    else         hist_q <= hist_d;
  end

  AST_RISE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_RISE && evt_o) |-> (lvl_i && !$past(lvl_i))); // R5
  AST_FALL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_FALL && evt_o) |-> (!lvl_i && $past(lvl_i))); // R4
  AST_BOTH_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_BOTH && evt_o) |-> (lvl_i != $past(lvl_i))); // R6

endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
  import xirq_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          standby_i,
  input  logic [DW-1:0] req_i,
  input  logic [1:0]    bus_addr_i,
  input  logic          bus_we_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);

  localparam int FIELDS = DW / 2;
  localparam int N_IN   = 2 * FIELDS;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  // Registers.
  logic [DW-1:0]   mode_hi_q, mode_hi_d;
  logic [DW-1:0]   mode_lo_q, mode_lo_d;
  logic [N_IN-1:0] flag_q, flag_d;
  logic [DW-1:0]   en_q, en_d;
  logic            mode_hi_ce, mode_lo_ce, en_ce;

  logic            flag_wr;
  logic [N_IN-1:0] clr_mask;
  logic [N_IN-1:0] lvl_s;
  logic [N_IN-1:0] evt;
  logic [N_IN-1:0] reload;
  logic [2*N_IN-1:0] mode_all_q, mode_all_d;

  xirq_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_s_n),
    .d_i    (req_i),
    .q_o    (lvl_s)
  );

  // Control register next state.
  always_comb begin
    mode_hi_d  = mode_hi_q;
    mode_lo_d  = mode_lo_q;
    en_d       = en_q;
    mode_hi_ce = 1'b0;
    mode_lo_ce = 1'b0;
    en_ce      = 1'b0;
    if (standby_i) begin
      mode_hi_d  = '0;
      mode_lo_d  = '0;
      en_d       = '0;
      mode_hi_ce = 1'b1;
      mode_lo_ce = 1'b1;
      en_ce      = 1'b1;
    end else if (bus_we_i) begin
      case (bus_addr_i)
        ADDR_MODE_HI: begin mode_hi_d = bus_wdata_i; mode_hi_ce = 1'b1; end
        ADDR_MODE_LO: begin mode_lo_d = bus_wdata_i; mode_lo_ce = 1'b1; end
        ADDR_ENABLE:  begin en_d      = bus_wdata_i; en_ce      = 1'b1; end
        default: ;
      endcase
    end
  end

  assign mode_all_q = {mode_hi_q, mode_lo_q};
  assign mode_all_d = {mode_hi_d, mode_lo_d};

  // Per-input detectors.
  for (genvar i = 0; i < N_IN; i++) begin : g_det
    assign reload[i] = (mode_all_d[2*i +: 2] != mode_all_q[2*i +: 2]);

    xirq_detect i_det (
      .clk_i    (clk_i),
      .rst_ni   (rst_s_n),
      .lvl_i    (lvl_s[i]),
      .mode_i   (sense_e'(mode_all_q[2*i +: 2])),
      .reload_i (reload[i]),
      .evt_o    (evt[i])
    );
  end

  // Flag next state: standby over event over clear.
  assign flag_wr  = bus_we_i && (bus_addr_i == ADDR_FLAGS);
  assign clr_mask = flag_wr ? ~bus_wdata_i : '0;

  always_comb begin
    if (standby_i) flag_d = '0;
    else           flag_d = evt | (flag_q & ~clr_mask);
  end

  always_ff @(posedge clk_i or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_hi_q <= '0;
      mode_lo_q <= '0;
      en_q      <= '0;
      flag_q    <= '0;
    end else begin
      if (mode_hi_ce) mode_hi_q <= mode_hi_d;
      if (mode_lo_ce) mode_lo_q <= mode_lo_d;
      if (en_ce)      en_q      <= en_d;
      flag_q <= flag_d;
    end
  end

  // Read path and combined request.
  always_comb begin
    case (bus_addr_i)
      ADDR_MODE_HI: bus_rdata_o = mode_hi_q;
      ADDR_MODE_LO: bus_rdata_o = mode_lo_q;
      ADDR_FLAGS:   bus_rdata_o = flag_q;
      default:      bus_rdata_o = en_q;
    endcase
  end

  assign irq_o = |(flag_q & en_q);

  // Assertions.
  AST_STANDBY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    standby_i |=> (mode_hi_q == '0 && mode_lo_q == '0 && flag_q == '0 && en_q == '0)); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (en_q == '0) |-> !irq_o); // R9

  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_s_n)
      $rose(flag_q[i]) |-> $past(evt[i])); // R7
    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_s_n)
      (flag_wr && !bus_wdata_i[i] && !evt[i] && !standby_i) |=> !flag_q[i]); // R7
    AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_s_n)
      (evt[i] && !standby_i) |=> flag_q[i]); // R8
    AST_LEVEL_SETS: assert property (@(posedge clk_i) disable iff (!rst_s_n)
      (mode_all_q[2*i +: 2] == 2'b00 && !lvl_s[i] && !reload[i] && !standby_i) |=> flag_q[i]); // R3
    AST_MODE_CHANGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_s_n)
      (reload[i] && !flag_q[i]) |=> !flag_q[i]); // R11
  end

endmodule

// File: tb/test_xirq_unit.sv
module test_xirq_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       standby;
  logic [7:0] req;
  logic [1:0] addr;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  xirq_unit i_xirq_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .standby_i   (standby),
    .req_i       (req),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  typedef struct packed {
    logic [2:0] idx;
    logic [1:0] mode;
    logic       from_lvl;
    logic       to_lvl;
    logic       hit;
  } vec_t;

  // Input, mode, level before, level after, flag expected (R3..R6).
  localparam vec_t VEC [10] = '{
    '{3'd0, 2'b01, 1'b1, 1'b0, 1'b1},
    '{3'd1, 2'b01, 1'b0, 1'b1, 1'b0},
    '{3'd2, 2'b10, 1'b0, 1'b1, 1'b1},
    '{3'd3, 2'b10, 1'b1, 1'b0, 1'b0},
    '{3'd4, 2'b11, 1'b1, 1'b0, 1'b1},
    '{3'd5, 2'b11, 1'b0, 1'b1, 1'b1},
    '{3'd6, 2'b00, 1'b1, 1'b0, 1'b1},
    '{3'd7, 2'b00, 1'b1, 1'b1, 1'b0},
    '{3'd7, 2'b01, 1'b1, 1'b1, 1'b0},
    '{3'd6, 2'b10, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input logic ok, input string req_tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #100000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [15:0] modes;
    rst_n = 1'b0; standby = 1'b0; req = 8'hFF;
    addr = 2'd0; we = 1'b0; wdata = 8'h00;
    #21 rst_n = 1'b1;
    settle();

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 8'h00, "R1", d, 0);
    end
    check(irq == 1'b0, "R1", irq, 0);

    // R2: read-back
    wr(2'd0, 8'hB4); rd(2'd0, d); check(d == 8'hB4, "R2", d, 8'hB4);
    wr(2'd1, 8'h1E); rd(2'd1, d); check(d == 8'h1E, "R2", d, 8'h1E);
    wr(2'd3, 8'h5A); rd(2'd3, d); check(d == 8'h5A, "R2", d, 8'h5A);
    wr(2'd3, 8'h00);
    // R2: field of input 5 is bits 3:2 of address 0
    wr(2'd1, 8'h00); wr(2'd0, 8'h04);
    settle(); wr(2'd2, 8'h00);
    @(negedge clk); req[5] = 1'b0;
    settle(); rd(2'd2, d); check(d == 8'h20, "R2", d, 8'h20);
    req = 8'hFF; wr(2'd0, 8'h00); settle(); wr(2'd2, 8'h00);

    // Table of sense-mode vectors
    for (int v = 0; v < 10; v++) begin
      modes = 16'h0000;
      modes[2*VEC[v].idx +: 2] = VEC[v].mode;
      req = 8'hFF;
      wr(2'd0, modes[15:8]); wr(2'd1, modes[7:0]);
      @(negedge clk); req[VEC[v].idx] = VEC[v].from_lvl;
      settle(); wr(2'd2, 8'h00);
      @(negedge clk); req[VEC[v].idx] = VEC[v].to_lvl;
      settle(); rd(2'd2, d);
      check(d == (8'(VEC[v].hit) << VEC[v].idx), mode_tag(VEC[v].mode), d,
            8'(VEC[v].hit) << VEC[v].idx);
      req = 8'hFF; wr(2'd0, 8'h00); wr(2'd1, 8'h00); settle(); wr(2'd2, 8'h00);
    end

    // R12: latency of three edges, falling mode on input 0
    wr(2'd1, 8'h01); settle(); wr(2'd2, 8'h00);
    addr = 2'd2;
    @(negedge clk); req[0] = 1'b0;
    repeat (2) @(posedge clk);
    #1 check(rdata[0] == 1'b0, "R12", rdata[0], 0);
    @(posedge clk);
    #1 check(rdata[0] == 1'b1, "R12", rdata[0], 1);
    req = 8'hFF; wr(2'd1, 8'h00); settle(); wr(2'd2, 8'h00);

    // R7: write-zero clears, write-one keeps
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    @(negedge clk); req = 8'h00;
    settle(); rd(2'd2, d); check(d == 8'hFF, "R6", d, 8'hFF);
    wr(2'd2, 8'hF0); rd(2'd2, d); check(d == 8'hF0, "R7", d, 8'hF0);

    // R9: masking of the combined output
    wr(2'd3, 8'h00); #1 check(irq == 1'b0, "R9", irq, 0);
    wr(2'd3, 8'h0F); #1 check(irq == 1'b0, "R9", irq, 0);
    wr(2'd3, 8'h10); #1 check(irq == 1'b1, "R9", irq, 1);
    rd(2'd2, d); check(d == 8'hF0, "R9", d, 8'hF0);

    // R10: standby clears everything
    req = 8'hFF; settle();
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 8'h00, "R10", d, 0);
    end
    check(irq == 1'b0, "R10", irq, 0);

    // R8 and R3: clear while the level is still low, then after release
    @(negedge clk); req[3] = 1'b0;
    settle(); rd(2'd2, d); check(d == 8'h08, "R3", d, 8'h08);
    wr(2'd2, 8'h00); rd(2'd2, d); check(d == 8'h08, "R8", d, 8'h08);
    @(negedge clk); req[3] = 1'b1;
    settle(); wr(2'd2, 8'h00);
    rd(2'd2, d); check(d == 8'h00, "R3", d, 0);

    // R11: mode changes on a static high input and a static low input
    wr(2'd1, 8'h10); wr(2'd1, 8'h20); wr(2'd1, 8'h30);
    settle(); rd(2'd2, d); check(d == 8'h00, "R11", d, 0);
    wr(2'd1, 8'h04);
    @(negedge clk); req[1] = 1'b0;
    settle(); wr(2'd2, 8'h00);
    wr(2'd1, 8'h08); wr(2'd1, 8'h0C); wr(2'd1, 8'h04);
    settle(); rd(2'd2, d); check(d == 8'h00, "R11", d, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule